// File: doc/BRIEF.md
# Command-Coded Configuration Bus Slave

This block sits on a host-side 16-bit parallel bus and gives the host access to a small bank of configuration registers. The registers have no addresses of their own. The host first issues a command phase, which is a write with the address line high. The low byte of that word becomes the current command code. The host then performs data phases with the address line low. Each data phase moves one 16-bit word to or from whatever the latched code selects. A word counter advances on every data phase. This lets a register wider than one word be moved over several accesses, low word first.

The bank holds sixteen 8-bit endpoint configuration entries and one 32-bit setup register. A lock guards writes to both. A resume event sets the lock, and so does a dedicated command that has no data phase. The lock clears only when the host sends a fixed key word after the unlock command. Reads are never blocked by the lock.

The bus has no handshake and applies no back-pressure. Every qualified strobe is accepted in the cycle it is sampled. Each strobe is one clock wide and counts as one access. Read data is registered and stays on the bus until the next data-phase read.

Top module: `cmdbus_slave`

## Requirements
- R1: A write with `bus_cs` high and `bus_a0` high is a command phase. Bits [7:0] of `bus_wdata` become the command code and bits [15:8] are ignored.
- R2: Code 0x20+n writes endpoint entry n, and code 0x30+n reads it, for n from 0 to 15. Entry 0 is control OUT, entry 1 is control IN, and entry n+1 belongs to endpoint n. A write takes `bus_wdata[7:0]` and ignores the upper byte. A read returns the entry zero-extended to 16 bits.
- R3: `bus_rdata` changes only on the clock edge that samples a data-phase read, and it holds its value at all other times.
- R4: Code 0xC0 writes the 32-bit setup register and code 0xC1 reads it. Data word 0 carries bits [15:0] and data word 1 carries bits [31:16]. Further data writes are ignored, and further reads return 0.
- R5: The data word counter returns to 0 on every command phase and advances on every data-phase read or write. A 1-byte entry responds only at word 0: later writes are dropped and later reads return 0.
- R6: If no command has been received since reset, or the latched code is not defined, a data-phase write changes nothing and a data-phase read returns 0.
- R7: A pulse on `resume_evt` locks the bank. While the bank is locked, writes to endpoint entries and to the setup register are dropped, and reads still return the stored values.
- R8: Code 0xB0 followed by the data word 0xAA37 at word 0 clears the lock. Any other data word leaves the lock unchanged.
- R9: Code 0xD0 sets the lock in the same cycle that the command phase is sampled. It needs no data phase.
- R10: If a resume pulse and an unlock key write arrive in the same cycle, the bank stays locked.
- R11: An access is ignored when `bus_cs` is low or when `bus_rd` and `bus_wr` are both high. Such an access changes no register, no counter and no read data.
- R12: After reset, every entry and the setup register read 0, `bus_rdata` is 0, and the bank is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_a0 | input | 1 | High selects command phase, low selects data phase |
| bus_wdata | input | 16 | Write data / command word |
| bus_rdata | output | 16 | Registered read data |
| resume_evt | input | 1 | One-cycle resume indication; sets the lock |

## Verification
Two lock events can fall in the same cycle. A resume pulse can land on the very edge that samples a correct unlock key write. The bench provokes this by raising `resume_evt` together with the 0xAA37 data write. It then judges the outcome at the ports: it attempts an endpoint write and reads the entry back, and the entry must still hold its old value. A second collision is between a read strobe and a write strobe raised together. The bench judges this by showing that neither the stored entry nor `bus_rdata` moved.

// File: rtl/cmdbus_pkg.sv
package cmdbus_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 8;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CFG_WR,
    TGT_CFG_RD,
    TGT_SETUP_WR,
    TGT_SETUP_RD,
    TGT_UNLOCK
  } tgt_e;

  localparam logic [3:0] GRP_CFG_WR = 4'h2;
  localparam logic [3:0] GRP_CFG_RD = 4'h3;
  localparam logic [CODE_W-1:0] OP_SETUP_WR = 8'hC0;
  localparam logic [CODE_W-1:0] OP_SETUP_RD = 8'hC1;
  localparam logic [CODE_W-1:0] OP_UNLOCK   = 8'hB0;
  localparam logic [CODE_W-1:0] OP_RELOCK   = 8'hD0;
  localparam logic [WORD_W-1:0] UNLOCK_KEY  = 16'hAA37;
endpackage

// File: rtl/cmdbus_decoder.sv
module cmdbus_decoder
  import cmdbus_pkg::*;
#(
  parameter int N_CFG = 16,
  parameter int CNT_W = 3,
  localparam int IDX_W = $clog2(N_CFG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic              data_stb,
  input  logic [CODE_W-1:0] code_in,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  cfg_idx,
  output logic [CNT_W-1:0]  word_idx,
  output logic              relock_now
);
  logic [CODE_W-1:0] code_q;
  logic              valid_q;
  logic              idx_ok;

  // Latch the code on a command phase; count data words after it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      valid_q  <= 1'b0;
      word_idx <= '0;
    end else if (cmd_stb) begin
      code_q   <= code_in;
      valid_q  <= (code_in != OP_RELOCK);
      word_idx <= '0;
    end else if (data_stb && (word_idx != {CNT_W{1'b1}})) begin
      word_idx <= word_idx + 1'b1;
    end
  end

  // Relock needs no data phase: it acts on the command edge itself.
  assign relock_now = cmd_stb && (code_in == OP_RELOCK);

  assign idx_ok  = int'(code_q[3:0]) < N_CFG;
  assign cfg_idx = code_q[IDX_W-1:0];

  always_comb begin
    tgt = TGT_NONE;
    if (valid_q) begin
      if (code_q[7:4] == GRP_CFG_WR && idx_ok)      tgt = TGT_CFG_WR;
      else if (code_q[7:4] == GRP_CFG_RD && idx_ok) tgt = TGT_CFG_RD;
      else if (code_q == OP_SETUP_WR)               tgt = TGT_SETUP_WR;
      else if (code_q == OP_SETUP_RD)               tgt = TGT_SETUP_RD;
      else if (code_q == OP_UNLOCK)                 tgt = TGT_UNLOCK;
    end
  end
endmodule

// File: rtl/cmdbus_lock.sv
module cmdbus_lock
  import cmdbus_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resume_evt,
  input  logic              relock_now,
  input  logic              data_wr,
  input  tgt_e              tgt,
  input  logic [CNT_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] wdata,
  output logic              unlock_hit,
  output logic              locked
);
  assign unlock_hit = data_wr && (tgt == TGT_UNLOCK) &&
                      (word_idx == '0) && (wdata == UNLOCK_KEY);

  // Locking events take priority over the key.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        locked <= 1'b0;
    else if (resume_evt || relock_now) locked <= 1'b1;
    else if (unlock_hit)               locked <= 1'b0;
  end
endmodule

// File: rtl/cmdbus_cfg_regs.sv
module cmdbus_cfg_regs
  import cmdbus_pkg::*;
#(
  parameter int N_CFG       = 16,
  parameter int CFG_W       = 8,
  parameter int SETUP_WORDS = 2,
  localparam int IDX_W = $clog2(N_CFG),
  localparam int SEL_W = (SETUP_WORDS > 1) ? $clog2(SETUP_WORDS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          locked,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [CFG_W-1:0]              cfg_wd,
  input  logic                          setup_we,
  input  logic [SEL_W-1:0]              setup_sel,
  input  logic [WORD_W-1:0]             setup_wd,
  output logic [CFG_W-1:0]              cfg_rd,
  output logic [WORD_W-1:0]             setup_rd,
  output logic [N_CFG*CFG_W-1:0]        cfg_flat,
  output logic [SETUP_WORDS*WORD_W-1:0] setup_flat
);
  for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
    logic [CFG_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                            q <= '0;
      else if (cfg_we && !locked && cfg_idx == IDX_W'(i))    q <= cfg_wd;
    end
    assign cfg_flat[i*CFG_W +: CFG_W] = q;
  end

  for (genvar w = 0; w < SETUP_WORDS; w++) begin : g_setup
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                              q <= '0;
      else if (setup_we && !locked && setup_sel == SEL_W'(w))  q <= setup_wd;
    end
    assign setup_flat[w*WORD_W +: WORD_W] = q;
  end

  assign cfg_rd   = cfg_flat[cfg_idx*CFG_W +: CFG_W];
  assign setup_rd = setup_flat[setup_sel*WORD_W +: WORD_W];
endmodule

// File: rtl/cmdbus_slave.sv
module cmdbus_slave
  import cmdbus_pkg::*;
#(
  parameter int N_CFG       = 16,
  parameter int CFG_W       = 8,
  parameter int SETUP_WORDS = 2,
  parameter int CNT_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_a0,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              resume_evt
);
  localparam int IDX_W = $clog2(N_CFG);
  localparam int SEL_W = (SETUP_WORDS > 1) ? $clog2(SETUP_WORDS) : 1;

  logic cmd_stb, data_wr, data_rd, single;
  tgt_e tgt;
  logic [IDX_W-1:0] cfg_idx;
  logic [CNT_W-1:0] word_idx;
  logic relock_now, unlock_hit, locked_q;
  logic cfg_we, setup_we, setup_in_range;
  logic [CFG_W-1:0]  cfg_rd;
  logic [WORD_W-1:0] setup_rd, rd_next;
  logic [N_CFG*CFG_W-1:0]        cfg_flat;
  logic [SETUP_WORDS*WORD_W-1:0] setup_flat;

  // Exactly one strobe, with chip select, qualifies an access.
  assign single  = bus_cs && (bus_rd ^ bus_wr);
  assign cmd_stb = single && bus_wr && bus_a0;
  assign data_wr = single && bus_wr && !bus_a0;
  assign data_rd = single && bus_rd && !bus_a0;

  cmdbus_decoder #(.N_CFG(N_CFG), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb),
    .data_stb(data_wr || data_rd), .code_in(bus_wdata[CODE_W-1:0]),
    .tgt(tgt), .cfg_idx(cfg_idx), .word_idx(word_idx),
    .relock_now(relock_now)
  );

  cmdbus_lock #(.CNT_W(CNT_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .resume_evt(resume_evt),
    .relock_now(relock_now), .data_wr(data_wr), .tgt(tgt),
    .word_idx(word_idx), .wdata(bus_wdata),
    .unlock_hit(unlock_hit), .locked(locked_q)
  );

  assign setup_in_range = int'(word_idx) < SETUP_WORDS;
  assign cfg_we   = data_wr && (tgt == TGT_CFG_WR) && (word_idx == '0);
  assign setup_we = data_wr && (tgt == TGT_SETUP_WR) && setup_in_range;

  cmdbus_cfg_regs #(.N_CFG(N_CFG), .CFG_W(CFG_W), .SETUP_WORDS(SETUP_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .locked(locked_q),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wd(bus_wdata[CFG_W-1:0]),
    .setup_we(setup_we), .setup_sel(word_idx[SEL_W-1:0]), .setup_wd(bus_wdata),
    .cfg_rd(cfg_rd), .setup_rd(setup_rd),
    .cfg_flat(cfg_flat), .setup_flat(setup_flat)
  );

  always_comb begin
    rd_next = '0;
    case (tgt)
      TGT_CFG_RD:   if (word_idx == '0) rd_next = WORD_W'(cfg_rd);
      TGT_SETUP_RD: if (setup_in_range) rd_next = setup_rd;
      default:      rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (data_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/cmdbus_checker.sv
module cmdbus_checker
  import cmdbus_pkg::*;
#(
  parameter int CFG_BITS   = 128,
  parameter int SETUP_BITS = 32,
  parameter int CNT_W      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  resume_evt,
  input logic                  cmd_stb,
  input logic                  data_rd,
  input logic                  relock_now,
  input logic                  unlock_hit,
  input logic                  locked_q,
  input tgt_e                  tgt,
  input logic [CNT_W-1:0]      word_idx,
  input logic [WORD_W-1:0]     bus_rdata,
  input logic [CFG_BITS-1:0]   cfg_flat,
  input logic [SETUP_BITS-1:0] setup_flat
);
  a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> $stable(bus_rdata));

  a_r5_cmd_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> (word_idx == '0));

  a_r6_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && tgt == TGT_NONE) |=> (bus_rdata == '0));

  a_r7_resume_locks: assert property (@(posedge clk) disable iff (!rst_n)
    resume_evt |=> locked_q);

  a_r7_locked_regs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> ($stable(cfg_flat) && $stable(setup_flat)));

  a_r9_relock_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    relock_now |=> locked_q);

  a_r10_resume_beats_key: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_evt && unlock_hit) |=> locked_q);
endmodule

bind cmdbus_slave cmdbus_checker #(
  .CFG_BITS(N_CFG*CFG_W), .SETUP_BITS(SETUP_WORDS*cmdbus_pkg::WORD_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .resume_evt(resume_evt), .cmd_stb(cmd_stb),
  .data_rd(data_rd), .relock_now(relock_now), .unlock_hit(unlock_hit),
  .locked_q(locked_q), .tgt(tgt), .word_idx(word_idx), .bus_rdata(bus_rdata),
  .cfg_flat(cfg_flat), .setup_flat(setup_flat)
);

// File: tb/tb_cmdbus_slave.sv
module tb_cmdbus_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_a0 = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic resume_evt = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] exp_cfg [16];
  logic [15:0] v;

  always #4 clk = ~clk;

  cmdbus_slave dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_a0(bus_a0), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .resume_evt(resume_evt)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic cs, input logic rd, input logic wr,
                     input logic a0, input logic [15:0] d, input logic res);
    @(negedge clk);
    bus_cs = cs; bus_rd = rd; bus_wr = wr; bus_a0 = a0; bus_wdata = d; resume_evt = res;
    @(negedge clk);
    bus_cs = 0; bus_rd = 0; bus_wr = 0; bus_a0 = 0; bus_wdata = '0; resume_evt = 0;
  endtask

  task automatic cmd(input logic [15:0] d);  acc(1, 0, 1, 1, d, 0); endtask
  task automatic wdat(input logic [15:0] d); acc(1, 0, 1, 0, d, 0); endtask
  task automatic rdat(output logic [15:0] d);
    acc(1, 1, 0, 0, 16'h0, 0);
    d = bus_rdata;
  endtask
  task automatic read_cfg(input int n, output logic [15:0] d);
    cmd(16'h0030 + 16'(n));
    rdat(d);
  endtask
  task automatic unlock();
    cmd(16'h00B0);
    wdat(16'hAA37);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R12 rdata after reset", bus_rdata, 16'h0);
    rdat(v); check("R6 data read with no command", v, 16'h0);
    for (int n = 0; n < 16; n++) begin
      read_cfg(n, v); check("R12 entry zero after reset", v, 16'h0);
    end
    cmd(16'h00C1);
    rdat(v); check("R12 setup low zero", v, 16'h0);
    rdat(v); check("R12 setup high zero", v, 16'h0);

    // R1/R2 sweep: junk upper bytes on both command and data words.
    for (int n = 0; n < 16; n++) begin
      exp_cfg[n] = 8'((n * 37 + 11) & 8'hFF);
      cmd({8'(8'hA0 + n), 8'(8'h20 + n)});
      wdat({8'h5C, exp_cfg[n]});
    end
    for (int n = 0; n < 16; n++) begin
      read_cfg(n, v); check("R1 R2 entry readback", v, {8'h00, exp_cfg[n]});
    end

    // R3: read data holds across idle, writes and commands.
    read_cfg(7, v);
    repeat (3) @(negedge clk);
    check("R3 rdata held idle", bus_rdata, {8'h00, exp_cfg[7]});
    cmd(16'h0021); wdat(16'h0042); exp_cfg[1] = 8'h42;
    check("R3 rdata held over write", bus_rdata, {8'h00, exp_cfg[7]});

    // R5: a 1-byte entry responds only at word 0.
    cmd(16'h0025); wdat(16'h00E1); wdat(16'h00E2); exp_cfg[5] = 8'hE1;
    cmd(16'h0035);
    rdat(v); check("R5 entry word0", v, 16'h00E1);
    rdat(v); check("R5 entry word1 zero", v, 16'h0);

    // R4: wide register, low word first.
    cmd(16'h00C0); wdat(16'h1234); wdat(16'hABCD); wdat(16'hFFFF);
    cmd(16'h00C1);
    rdat(v); check("R4 setup low word", v, 16'h1234);
    rdat(v); check("R4 setup high word", v, 16'hABCD);
    rdat(v); check("R4 setup beyond width", v, 16'h0);
    cmd(16'h00C1);
    rdat(v); check("R5 new command restarts count", v, 16'h1234);

    // R6: undefined code.
    cmd(16'h0077); wdat(16'h0099);
    rdat(v); check("R6 unknown code read", v, 16'h0);
    read_cfg(0, v); check("R6 unknown code write ignored", v, {8'h00, exp_cfg[0]});

    // R11: deselected access and double strobe.
    cmd(16'h0020);
    acc(0, 0, 1, 0, 16'h0011, 0);
    acc(1, 1, 1, 0, 16'h0022, 0);
    wdat(16'h0033); exp_cfg[0] = 8'h33;
    read_cfg(0, v); check("R11 ignored accesses kept count", v, 16'h0033);
    cmd(16'h0030);
    acc(1, 1, 1, 0, 16'h0, 0);
    check("R11 double strobe rdata unchanged", bus_rdata, 16'h0033);

    // R7: resume locks writes, reads unaffected.
    acc(0, 0, 0, 0, 16'h0, 1);
    cmd(16'h0020); wdat(16'h0066);
    read_cfg(0, v); check("R7 locked entry write dropped", v, 16'h0033);
    cmd(16'h00C0); wdat(16'h5555);
    cmd(16'h00C1); rdat(v); check("R7 locked setup write dropped", v, 16'h1234);

    // R8: wrong key keeps lock, right key clears it.
    cmd(16'h00B0); wdat(16'hAA36);
    cmd(16'h0020); wdat(16'h0067);
    read_cfg(0, v); check("R8 wrong key stays locked", v, 16'h0033);
    unlock();
    cmd(16'h0020); wdat(16'h0068); exp_cfg[0] = 8'h68;
    read_cfg(0, v); check("R8 key unlocks", v, 16'h0068);

    // R9: relock command with no data phase.
    cmd(16'h00D0);
    cmd(16'h0022); wdat(16'h0077);
    read_cfg(2, v); check("R9 relock blocks writes", v, {8'h00, exp_cfg[2]});
    unlock();

    // R10: resume on the same edge as a correct key.
    cmd(16'h00B0);
    acc(1, 0, 1, 0, 16'hAA37, 1);
    cmd(16'h0023); wdat(16'h0078);
    read_cfg(3, v); check("R10 resume beats key", v, {8'h00, exp_cfg[3]});
    unlock();
    cmd(16'h0023); wdat(16'h0079);
    read_cfg(3, v); check("R8 unlock after collision", v, 16'h0079);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule